// File: doc/BRIEF.md
# Instruction Namespace Control Register Bank

This block keeps, for every privilege level, a 32-bit namespace word that tells the instruction decoder how to read each opcode. It also keeps a saved-namespace register and a handler-namespace table. The namespace word acts as hidden opcode bits that go with every instruction. Bit 0 picks one of two layouts. In native mode the word carries a 16-bit opcode page, an endian flag and optional flag bits. In foreign mode it carries a 7-bit index into a table of foreign instruction sets.

Software writes the registers through a CSR port. Every value is checked against what the implementation can hold. A value that cannot be held is never stored and never trimmed: the register keeps its old value and a one-cycle illegal-write trap request goes out, so that software can take over by emulation. Trap-entry and trap-exit strobes exchange the namespace with the saved copy in a single clock edge. A `swap_done` pulse then tells the fetch logic that it may redirect the PC. The decoder-facing outputs show the namespace of the privilege level that is currently executing.

Top module: `nsctl_top`

## Requirements
- R1: After reset every namespace, saved-namespace and handler-table entry reads zero (native mode, page 0, little-endian). `ns_valid` is 0 while reset is held and 1 afterwards whenever `exec_priv` is below NUM_PRIV. `csr_illegal` and `swap_done` are 0 after reset.
- R2: The decoder fields come from the `exec_priv` namespace word. `ns_foreign` is bit 0. When bit 0 is 0, `ns_page` is bits 5:1, `ns_big_endian` is bit 6 and `ns_arch` is 0. When bit 0 is 1, `ns_arch` is bits 7:1 and `ns_page`/`ns_big_endian` are 0. For an out-of-range `exec_priv`, all outputs are zero.
- R3: A native-mode value (bit 0 = 0) is legal only under three conditions. Its page (bits 5:1) must be set in PAGE_MASK. Bits 15..23 must be zero. Any set bit in 7..14 or 24..31 must also be set in FLAG_MASK. A legal write is stored at the next edge and raises no trap.
- R4: A write that fails the check is rejected. This covers an illegal value, `csr_sel` = 3, or `csr_priv` ≥ NUM_PRIV. A rejected write changes no register, and `csr_illegal` is 1 for exactly the one cycle after that write.
- R5: A foreign-mode value (bit 0 = 1) is legal only when its index (bits 7:1) is set in ARCH_MASK and bits 31:8 are zero.
- R6: `csr_sel` selects the target register: 0 = namespace, 1 = saved namespace, 2 = handler-table entry `csr_idx`. Writes to the saved namespace and to the handler table pass the same legality check.
- R7: On `trap_enter` for level `trap_priv`, two things happen in the same edge: the saved namespace takes the old namespace, and the namespace takes the handler entry. `swap_done` is 1 in the following cycle, when the outputs already show the new namespace.
- R8: On `trap_exit`, two things happen in one edge: the namespace takes the saved namespace, and the saved namespace is reloaded from the handler entry. `swap_done` follows as in R7.
- R9: With VECTORED = 1, the handler entry used for entry and for the exit reload is the one indexed by `trap_cause`.
- R10: A trap strobe in the same cycle as a CSR write drops the write and raises no illegal trap. When `trap_enter` and `trap_exit` arrive together, only the entry is carried out.
- R11: Writes and traps addressed to one privilege level leave every other level unchanged. A trap to a level ≥ NUM_PRIV changes nothing and gives no `swap_done`.
- R12: `csr_rdata` returns the register named by `csr_priv`/`csr_sel`/`csr_idx` without delay. It returns zero for `csr_sel` = 3 or an out-of-range level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_priv | input | PRIV_W | Privilege level addressed by the CSR port |
| csr_sel | input | 2 | Register select: 0 namespace, 1 saved, 2 handler table |
| csr_idx | input | CAUSE_W | Handler-table entry for write and read |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Read value of the addressed register |
| csr_illegal | output | 1 | Illegal-write trap request, one cycle after a rejected write |
| trap_enter | input | 1 | Trap-entry strobe |
| trap_exit | input | 1 | Trap-exit strobe |
| trap_priv | input | PRIV_W | Privilege level taking the trap |
| trap_cause | input | CAUSE_W | Trap cause, indexes the handler table |
| swap_done | output | 1 | Namespace swap committed; PC change may follow |
| exec_priv | input | PRIV_W | Privilege level currently executing |
| ns_word | output | 32 | Active namespace word |
| ns_foreign | output | 1 | Foreign-mode flag |
| ns_page | output | 5 | 16-bit opcode page (native mode) |
| ns_big_endian | output | 1 | Big-endian flag (native mode) |
| ns_arch | output | 7 | Foreign instruction-set index (foreign mode) |
| ns_valid | output | 1 | Hidden bits are valid for the decoder |

## Verification
The bench builds the block with three privilege levels. Because three levels need a 2-bit code, level 3 is out of range, which makes rejected level writes, ignored traps and the zeroed decoder outputs reachable. It uses a vectored four-entry handler table, and masks allowing pages 0, 1, 2 and 8, foreign indices 0, 1, 3 and 64, and flag bits 7 and 31. Each mask therefore has implemented and unimplemented neighbours, including the custom page and the custom foreign index, so the accept and reject paths of both layouts can be reached.

// File: rtl/nsctl_pkg.sv
package nsctl_pkg;

  localparam int NS_W = 32;

  typedef enum logic [1:0] {
    SEL_NS   = 2'd0,
    SEL_LAST = 2'd1,
    SEL_TRAP = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic       foreign;
    logic [4:0] page;
    logic       big_endian;
    logic [6:0] arch;
  } ns_fields_t;

  // Optional flag fields of the native layout (bits 7..14 and 24..31).
  localparam logic [NS_W-1:0] NATIVE_FLAG_FIELDS = 32'hFF00_7F80;
  // Mode, page and endian bits are always writable in native layout.
  localparam logic [NS_W-1:0] NATIVE_BASE_BITS   = 32'h0000_007F;

  function automatic ns_fields_t ns_decode(input logic [NS_W-1:0] v);
    ns_fields_t f;
    f = '0;
    f.foreign = v[0];
    if (v[0]) begin
      f.arch = v[7:1];
    end else begin
      f.page       = v[5:1];
      f.big_endian = v[6];
    end
    return f;
  endfunction

  function automatic logic ns_supported(input logic [NS_W-1:0] v,
                                        input logic [31:0]     page_mask,
                                        input logic [127:0]    arch_mask,
                                        input logic [NS_W-1:0] flag_mask);
    logic [NS_W-1:0] allowed;
    if (!v[0]) begin
      allowed = NATIVE_BASE_BITS | (flag_mask & NATIVE_FLAG_FIELDS);
      return page_mask[v[5:1]] && ((v & ~allowed) == '0);
    end
    return arch_mask[v[7:1]] && (v[31:8] == 24'h0);
  endfunction

endpackage

// File: rtl/nsctl_check.sv
module nsctl_check #(
  parameter logic [31:0]  PAGE_MASK = 32'h0000_0103,
  parameter logic [127:0] ARCH_MASK = 128'h1_0000_0000_0000_0007,
  parameter logic [31:0]  FLAG_MASK = 32'h0000_0000
) (
  input  logic [31:0] value,
  output logic        ok
);
  assign ok = nsctl_pkg::ns_supported(value, PAGE_MASK, ARCH_MASK, FLAG_MASK);
endmodule

// File: rtl/nsctl_bank.sv
module nsctl_bank #(
  parameter int CAUSE_W  = 3,
  parameter bit VECTORED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_ns,
  input  logic               we_last,
  input  logic               we_trap,
  input  logic [CAUSE_W-1:0] wr_idx,
  input  logic [31:0]        wdata,
  input  logic               do_enter,
  input  logic               do_exit,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [CAUSE_W-1:0] rd_idx,
  output logic [31:0]        ns_q,
  output logic [31:0]        last_q,
  output logic [31:0]        trap_rd
);
  localparam int TW    = VECTORED ? CAUSE_W : 1;
  localparam int DEPTH = VECTORED ? (1 << CAUSE_W) : 1;

  logic [31:0]   trap_tab [DEPTH];
  logic [TW-1:0] tix_wr, tix_rd, tix_cause;

  generate
    if (VECTORED) begin : g_vectored
      assign tix_wr    = wr_idx;
      assign tix_rd    = rd_idx;
      assign tix_cause = cause;
    end else begin : g_single
      logic unused_idx;
      assign unused_idx = ^{wr_idx, rd_idx, cause};
      assign tix_wr     = '0;
      assign tix_rd     = '0;
      assign tix_cause  = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) trap_tab[i] <= '0;
    end else if (we_trap) begin
      trap_tab[tix_wr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q   <= '0;
      last_q <= '0;
    end else if (do_enter) begin
      last_q <= ns_q;
      ns_q   <= trap_tab[tix_cause];
    end else if (do_exit) begin
      ns_q   <= last_q;
      last_q <= trap_tab[tix_cause];
    end else begin
      if (we_ns)   ns_q   <= wdata;
      if (we_last) last_q <= wdata;
    end
  end

  assign trap_rd = trap_tab[tix_rd];
endmodule

// File: rtl/nsctl_top.sv
module nsctl_top #(
  parameter int           NUM_PRIV  = 3,
  parameter int           CAUSE_W   = 3,
  parameter bit           VECTORED  = 1'b1,
  parameter logic [31:0]  PAGE_MASK = 32'h0000_0103,
  parameter logic [127:0] ARCH_MASK = 128'h1_0000_0000_0000_0007,
  parameter logic [31:0]  FLAG_MASK = 32'h0100_0080,
  localparam int          PRIV_W    = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [PRIV_W-1:0]  csr_priv,
  input  logic [1:0]         csr_sel,
  input  logic [CAUSE_W-1:0] csr_idx,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  output logic               csr_illegal,
  input  logic               trap_enter,
  input  logic               trap_exit,
  input  logic [PRIV_W-1:0]  trap_priv,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic               swap_done,
  input  logic [PRIV_W-1:0]  exec_priv,
  output logic [31:0]        ns_word,
  output logic               ns_foreign,
  output logic [4:0]         ns_page,
  output logic               ns_big_endian,
  output logic [6:0]         ns_arch,
  output logic               ns_valid
);
  import nsctl_pkg::*;

  logic [31:0] ns_arr   [NUM_PRIV];
  logic [31:0] last_arr [NUM_PRIV];
  logic [31:0] trap_arr [NUM_PRIV];

  // Named internal events
  logic wr_ok, trap_any, wr_go, csr_priv_ok, trap_priv_ok, exec_ok;
  logic wr_commit, wr_reject;
  logic [31:0] last_exec;
  logic ready_q;
  ns_fields_t fields;
  csr_sel_e sel;

  assign sel          = csr_sel_e'(csr_sel);
  assign csr_priv_ok  = int'(csr_priv)  < NUM_PRIV;
  assign trap_priv_ok = int'(trap_priv) < NUM_PRIV;
  assign exec_ok      = int'(exec_priv) < NUM_PRIV;
  assign trap_any     = trap_enter | trap_exit;
  assign wr_go        = csr_we & ~trap_any;
  assign wr_commit    = wr_go & wr_ok & csr_priv_ok & (sel != SEL_NONE);
  assign wr_reject    = wr_go & ~(wr_ok & csr_priv_ok & (sel != SEL_NONE));

  nsctl_check #(
    .PAGE_MASK(PAGE_MASK),
    .ARCH_MASK(ARCH_MASK),
    .FLAG_MASK(FLAG_MASK)
  ) u_check (
    .value(csr_wdata),
    .ok   (wr_ok)
  );

  generate
    for (genvar p = 0; p < NUM_PRIV; p++) begin : g_level
      logic hit_w, hit_t;
      assign hit_w = wr_commit && (csr_priv == PRIV_W'(p));
      assign hit_t = trap_priv == PRIV_W'(p);

      nsctl_bank #(
        .CAUSE_W (CAUSE_W),
        .VECTORED(VECTORED)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_ns   (hit_w && sel == SEL_NS),
        .we_last (hit_w && sel == SEL_LAST),
        .we_trap (hit_w && sel == SEL_TRAP),
        .wr_idx  (csr_idx),
        .wdata   (csr_wdata),
        .do_enter(trap_enter && hit_t),
        .do_exit (trap_exit && !trap_enter && hit_t),
        .cause   (trap_cause),
        .rd_idx  (csr_idx),
        .ns_q    (ns_arr[p]),
        .last_q  (last_arr[p]),
        .trap_rd (trap_arr[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_illegal <= 1'b0;
      swap_done   <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      csr_illegal <= wr_reject;
      swap_done   <= trap_any & trap_priv_ok;
      ready_q     <= 1'b1;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_priv_ok) begin
      unique case (sel)
        SEL_NS:   csr_rdata = ns_arr[csr_priv];
        SEL_LAST: csr_rdata = last_arr[csr_priv];
        SEL_TRAP: csr_rdata = trap_arr[csr_priv];
        default:  csr_rdata = '0;
      endcase
    end
  end

  assign ns_word       = exec_ok ? ns_arr[exec_priv]   : '0;
  assign last_exec     = exec_ok ? last_arr[exec_priv] : '0;
  assign fields        = ns_decode(ns_word);
  assign ns_foreign    = fields.foreign;
  assign ns_page       = fields.page;
  assign ns_big_endian = fields.big_endian;
  assign ns_arch       = fields.arch;
  assign ns_valid      = ready_q & exec_ok;
endmodule

// File: rtl/nsctl_sva.sv
module nsctl_sva #(
  parameter int NUM_PRIV = 3,
  parameter int PRIV_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic              trap_enter,
  input logic              trap_exit,
  input logic [PRIV_W-1:0] trap_priv,
  input logic [PRIV_W-1:0] exec_priv,
  input logic              csr_illegal,
  input logic              swap_done,
  input logic [31:0]       ns_word,
  input logic              ns_foreign,
  input logic [4:0]        ns_page,
  input logic              ns_big_endian,
  input logic [6:0]        ns_arch,
  input logic              wr_ok,
  input logic              wr_commit,
  input logic [31:0]       last_exec
);
  a_r3_commit_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !csr_illegal);

  a_r4_bad_value_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !trap_enter && !trap_exit && !wr_ok) |=> csr_illegal);

  a_r4_trap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> $past(csr_we));

  a_r10_trap_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (trap_enter || trap_exit)) |=> !csr_illegal);

  a_r7_swap_signalled: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && int'(trap_priv) < NUM_PRIV) |=> swap_done);

  a_r7_enter_saves: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && trap_priv == exec_priv) |=>
      (exec_priv != $past(exec_priv)) || (last_exec == $past(ns_word)));

  a_r8_exit_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_exit && !trap_enter && trap_priv == exec_priv) |=>
      (exec_priv != $past(exec_priv)) || (ns_word == $past(last_exec)));

  a_r2_foreign_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ns_foreign |-> (ns_page == 5'd0 && !ns_big_endian));

  a_r2_native_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !ns_foreign |-> (ns_arch == 7'd0));
endmodule

bind nsctl_top nsctl_sva #(
  .NUM_PRIV(NUM_PRIV),
  .PRIV_W  (PRIV_W)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_we       (csr_we),
  .trap_enter   (trap_enter),
  .trap_exit    (trap_exit),
  .trap_priv    (trap_priv),
  .exec_priv    (exec_priv),
  .csr_illegal  (csr_illegal),
  .swap_done    (swap_done),
  .ns_word      (ns_word),
  .ns_foreign   (ns_foreign),
  .ns_page      (ns_page),
  .ns_big_endian(ns_big_endian),
  .ns_arch      (ns_arch),
  .wr_ok        (wr_ok),
  .wr_commit    (wr_commit),
  .last_exec    (last_exec)
);

// File: tb/nsctl_top_tb.sv
`timescale 1ns/1ps
module nsctl_top_tb;
  localparam int NP = 3;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_priv = '0;
  logic [1:0]  csr_sel = '0;
  logic [1:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        trap_enter = 1'b0;
  logic        trap_exit = 1'b0;
  logic [1:0]  trap_priv = '0;
  logic [1:0]  trap_cause = '0;
  logic        swap_done;
  logic [1:0]  exec_priv = '0;
  logic [31:0] ns_word;
  logic        ns_foreign;
  logic [4:0]  ns_page;
  logic        ns_big_endian;
  logic [6:0]  ns_arch;
  logic        ns_valid;

  always #2.5 clk = ~clk;

  nsctl_top #(
    .NUM_PRIV (3),
    .CAUSE_W  (2),
    .VECTORED (1'b1),
    .PAGE_MASK(32'h0000_0107),
    .ARCH_MASK((128'h1 << 64) | 128'hB),
    .FLAG_MASK(32'h8000_0080)
  ) u_dut (.*);

  int total = 0;
  int bad = 0;
  logic [31:0] m_ns [NP];
  logic [31:0] m_last [NP];
  logic [31:0] m_trap [NP][NC];

  task automatic chk(input logic cond, input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Independent statement of the legal set for the bench's masks.
  function automatic logic legal(input logic [31:0] v);
    int idx;
    if (v[0] == 1'b0) begin
      idx = int'(v[5:1]);
      if (!(idx == 0 || idx == 1 || idx == 2 || idx == 8)) return 1'b0;
      return (v & 32'h7FFF_FF00) == 32'h0;
    end
    idx = int'(v[7:1]);
    if (!(idx == 0 || idx == 1 || idx == 3 || idx == 64)) return 1'b0;
    return v[31:8] == 24'h0;
  endfunction

  task automatic check_state(input string tag);
    logic [31:0] w;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < ((s == 2) ? NC : 1); i++) begin
          csr_priv = 2'(p); csr_sel = 2'(s); csr_idx = 2'(i);
          #0.02;
          if (p >= NP || s == 3) w = 32'h0;
          else if (s == 0) w = m_ns[p];
          else if (s == 1) w = m_last[p];
          else w = m_trap[p][i];
          chk(csr_rdata === w, {tag, " R12 rdata"}, csr_rdata, w);
        end
      end
    end
    w = (int'(exec_priv) < NP) ? m_ns[exec_priv] : 32'h0;
    chk(ns_word === w, {tag, " R2 ns_word"}, ns_word, w);
    chk(ns_foreign === w[0], {tag, " R2 foreign"}, 32'(ns_foreign), 32'(w[0]));
    chk(ns_page === (w[0] ? 5'd0 : w[5:1]), {tag, " R2 page"}, 32'(ns_page), 32'(w[0] ? 5'd0 : w[5:1]));
    chk(ns_big_endian === (!w[0] && w[6]), {tag, " R2 endian"}, 32'(ns_big_endian), 32'(!w[0] && w[6]));
    chk(ns_arch === (w[0] ? w[7:1] : 7'd0), {tag, " R2 arch"}, 32'(ns_arch), 32'(w[0] ? w[7:1] : 7'd0));
    chk(ns_valid === (int'(exec_priv) < NP), {tag, " R1 valid"}, 32'(ns_valid), 32'(int'(exec_priv) < NP));
  endtask

  // One clock of stimulus; the model is updated from the requirements.
  task automatic op(input logic we, input int pr, input int sel, input int idx, input logic [31:0] d,
                    input logic en, input logic ex, input int tpr, input int cause, input string tag);
    logic exp_ill, exp_swap;
    logic [31:0] t;
    exp_ill = 1'b0; exp_swap = 1'b0;
    if (en || ex) begin
      if (tpr < NP) begin
        exp_swap = 1'b1;
        if (en) begin
          m_last[tpr] = m_ns[tpr];
          m_ns[tpr] = m_trap[tpr][cause];
        end else begin
          t = m_trap[tpr][cause];
          m_ns[tpr] = m_last[tpr];
          m_last[tpr] = t;
        end
      end
    end else if (we) begin
      if (pr < NP && sel != 3 && legal(d)) begin
        if (sel == 0) m_ns[pr] = d;
        else if (sel == 1) m_last[pr] = d;
        else m_trap[pr][idx] = d;
      end else exp_ill = 1'b1;
    end
    csr_we = we; csr_priv = 2'(pr); csr_sel = 2'(sel); csr_idx = 2'(idx); csr_wdata = d;
    trap_enter = en; trap_exit = ex; trap_priv = 2'(tpr); trap_cause = 2'(cause);
    @(posedge clk); @(negedge clk);
    csr_we = 1'b0; trap_enter = 1'b0; trap_exit = 1'b0;
    chk(csr_illegal === exp_ill, {tag, " illegal flag"}, 32'(csr_illegal), 32'(exp_ill));
    chk(swap_done === exp_swap, {tag, " swap_done"}, 32'(swap_done), 32'(exp_swap));
    check_state(tag);
  endtask

  task automatic wr(input int pr, input int sel, input int idx, input logic [31:0] d, input string tag);
    op(1'b1, pr, sel, idx, d, 1'b0, 1'b0, 0, 0, tag);
  endtask

  task automatic t_reset;
    chk(ns_valid === 1'b0, "R1 valid in reset", 32'(ns_valid), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(csr_illegal === 1'b0, "R1 illegal after reset", 32'(csr_illegal), 32'h0);
    chk(swap_done === 1'b0, "R1 swap after reset", 32'(swap_done), 32'h0);
    check_state("R1 reset");
  endtask

  task automatic t_native;
    wr(0, 0, 0, 32'h8000_00D0, "R3 page8 BE flags");
    wr(0, 0, 0, 32'h0000_0042, "R3 page1 BE");
    wr(0, 0, 0, 32'h0000_0004, "R3 page2 LE");
  endtask

  task automatic t_illegal;
    wr(0, 0, 0, 32'h0001_0000, "R4 reserved bit");
    wr(0, 0, 0, 32'h0000_0006, "R4 page3 absent");
    wr(0, 0, 0, 32'h0100_0000, "R4 flag24 absent");
    wr(0, 0, 0, 32'h0000_0005, "R4 arch2 absent");
    wr(0, 0, 0, 32'h0000_0207, "R4 foreign high bit");
    wr(0, 3, 0, 32'h0000_0000, "R4 select3");
    wr(3, 0, 0, 32'h0000_0000, "R4 level3");
  endtask

  task automatic t_foreign;
    wr(0, 0, 0, 32'h0000_0081, "R5 arch64");
    wr(0, 0, 0, 32'h0000_0003, "R5 arch1");
    wr(0, 0, 0, 32'h0000_0001, "R5 arch0");
  endtask

  task automatic t_shadow;
    wr(0, 1, 0, 32'h0000_0004, "R6 saved legal");
    wr(0, 1, 0, 32'h0000_0006, "R6 saved illegal");
    wr(0, 2, 2, 32'h0000_0007, "R6 table2 legal");
    wr(0, 2, 1, 32'h0000_0004, "R6 table1 legal");
    wr(0, 2, 3, 32'h0000_0081, "R6 table3 legal");
    wr(0, 2, 0, 32'h8001_0000, "R6 table0 illegal");
  endtask

  task automatic t_enter;
    wr(0, 0, 0, 32'h0000_0042, "R7 setup");
    op(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 2, "R7 R9 enter cause2");
    @(negedge clk);
    chk(swap_done === 1'b0, "R7 swap one cycle", 32'(swap_done), 32'h0);
  endtask

  task automatic t_exit;
    op(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 0, 1, "R8 R9 exit cause1");
  endtask

  task automatic t_collide;
    op(1'b1, 0, 0, 0, 32'h0000_0002, 1'b1, 1'b0, 1, 0, "R10 write vs enter");
    op(1'b1, 0, 0, 0, 32'h0000_0006, 1'b0, 1'b1, 1, 0, "R10 bad write vs exit");
    op(1'b0, 0, 0, 0, 0, 1'b1, 1'b1, 0, 3, "R10 enter and exit");
  endtask

  task automatic t_levels;
    exec_priv = 2'd1;
    wr(1, 0, 0, 32'h0000_0043, "R11 level1 write");
    wr(2, 2, 0, 32'h0000_0003, "R11 level2 table");
    op(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 2, 0, "R11 level2 enter");
    op(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 3, 0, "R11 level3 enter ignored");
    exec_priv = 2'd2;
    #0.1;
    check_state("R11 exec level2");
    exec_priv = 2'd3;
    #0.1;
    check_state("R2 R12 exec level3");
    exec_priv = 2'd0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_ns[p] = '0; m_last[p] = '0;
      for (int i = 0; i < NC; i++) m_trap[p][i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_native();
    t_illegal();
    t_foreign();
    t_shadow();
    t_enter();
    t_exit();
    t_collide();
    t_levels();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule